// File: doc/BRIEF.md
# Serial Attenuator Word Programmer

This block sits on the host side of a board and drives a step attenuator that is set through a three-wire serial path: data, a shift clock and a latch strobe. A requester offers an attenuation in whole decibels over a valid/ready handshake. The block turns that value into an eight-bit control word, sends the word one bit at a time while the latch strobe is held low, and then pulses the strobe to commit the new setting.

The control word is the decibel value times four. The highest bit is always zero and the two lowest bits are always zero. Requests above 31 dB are clamped to 31 dB. Every edge on the three wires is derived from the system clock. The shift-clock half period and the strobe width are set as cycle counts, so the wire timing can be adapted to any system clock. The requester is held off until the strobe has fallen, so a word that is being sent cannot be disturbed.

Top module: `atten_ser_prog`

## Requirements
- R1: The word sent for a request of D dB (D at most 31) is D*4 in eight bits: bit 7 is 0, bits 6:2 carry D, and bits 1:0 are 0.
- R2: The word goes out least significant bit first. Bit i is driven on `ser_data` for one full shift-clock period, from the falling edge before its rising edge to the falling edge after it. `ser_data` changes only while `ser_clk` is low.
- R3: Each word has exactly eight rising edges on `ser_clk`. Every high phase and every low phase lasts `HALF_DIV` system cycles. The first rising edge comes `HALF_DIV` cycles after acceptance. `ser_clk` is low whenever no word is being shifted.
- R4: `ser_le` stays low during shifting. It rises on the falling edge that ends the eighth high phase, which is `HALF_DIV` cycles after the last rising edge. `ser_data` returns to 0 at the same moment.
- R5: `ser_le` stays high for exactly `LE_CYC` system cycles and then returns low.
- R6: `req_ready` falls in the cycle after a request is accepted. It stays low until the cycle in which `ser_le` returns low. A `req_valid` seen while `req_ready` is low is ignored.
- R7: A request above 31 dB is sent as the 31 dB word (8'h7C).
- R8: During reset and after reset, `ser_clk`, `ser_data` and `ser_le` are low. `req_ready` goes high two cycles after reset is released.
- R9: At the configured system clock period, the wire timing meets these minimums: each shift-clock phase is at least 30 ns, each shift-clock period is at least 100 ns, the strobe rises at least 10 ns after the last rising edge, and the strobe is high for at least 30 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request offered |
| req_db | input | DB_W | Requested attenuation in dB; values above 31 are clamped |
| req_ready | output | 1 | Block can accept a request |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator, LSB first |
| ser_le | output | 1 | Latch strobe that commits the shifted word |

## Verification
A wrong bit counter shows up at the ports as the wrong number of `ser_clk` rising edges. It is visible within one word, at the latch pulse, which rises early or late relative to the last rising edge. A corrupted shift register or word former changes the captured eight-bit value. This is seen at the first rising edge of `ser_le` after the fault. A stuck or mis-ordered state register shows up in the same cycle as a `req_ready` that disagrees with the per-cycle reference model, or as a strobe whose width differs from `LE_CYC`. Because the model is compared on every clock, each such fault is seen within one system cycle of its first effect on a pin.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned STEP_LSH = 2;
  localparam int unsigned WORD_W   = 1 + CODE_W + STEP_LSH;
  localparam int unsigned MAX_DB   = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } prog_state_e;
endpackage

// File: rtl/atten_word_fmt.sv
module atten_word_fmt
  import atten_prog_pkg::*;
#(
  parameter int unsigned DB_W = 6
) (
  input  logic [DB_W-1:0]   req_db,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned PAD_W = WORD_W - CODE_W - STEP_LSH;

  logic [CODE_W-1:0] code;

  generate
    if (DB_W > CODE_W) begin : g_clamp
      always_comb begin
        if (req_db > DB_W'(MAX_DB)) code = CODE_W'(MAX_DB);
        else                        code = req_db[CODE_W-1:0];
      end
    end else begin : g_pass
      always_comb code = CODE_W'(req_db);
    end
  endgenerate

  assign word = {{PAD_W{1'b0}}, code, {STEP_LSH{1'b0}}};
endmodule

// File: rtl/atten_span_timer.sv
module atten_span_timer #(
  parameter int unsigned SPAN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter
  import atten_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word_in,
  output logic              next_bit,
  output logic              last
);
  localparam int unsigned BW = $clog2(WORD_W);

  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;

  assign next_bit = sreg_q[1];
  assign last     = (bcnt_q == BW'(WORD_W - 1));

  always_comb begin
    sreg_d = sreg_q;
    bcnt_d = bcnt_q;
    if (load) begin
      sreg_d = word_in;
      bcnt_d = '0;
    end else if (shift) begin
      sreg_d = sreg_q >> 1;
      bcnt_d = bcnt_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bcnt_q <= '0;
    end else begin
      sreg_q <= sreg_d;
      bcnt_q <= bcnt_d;
    end
  end
endmodule

// File: rtl/atten_ser_prog.sv
module atten_ser_prog
  import atten_prog_pkg::*;
#(
  parameter int unsigned DB_W     = 6,
  parameter int unsigned HALF_DIV = 3,
  parameter int unsigned LE_CYC   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [DB_W-1:0] req_db,
  output logic            req_ready,
  output logic            ser_clk,
  output logic            ser_data,
  output logic            ser_le
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  prog_state_e state_q, state_d;
  logic sclk_q, sclk_d;
  logic sdat_q, sdat_d;
  logic le_q, le_d;

  logic [WORD_W-1:0] word;
  logic half_tick, le_tick;
  logic accept, shift_en, next_bit, last_bit;

  atten_word_fmt #(.DB_W(DB_W)) u_fmt (
    .req_db (req_db),
    .word   (word)
  );

  atten_span_timer #(.SPAN(HALF_DIV)) u_half (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (state_q == ST_SHIFT),
    .tick  (half_tick)
  );

  atten_span_timer #(.SPAN(LE_CYC)) u_strobe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (state_q == ST_LATCH),
    .tick  (le_tick)
  );

  atten_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .shift    (shift_en),
    .word_in  (word),
    .next_bit (next_bit),
    .last     (last_bit)
  );

  assign req_ready = (state_q == ST_IDLE) && rst_sync_n;
  assign accept    = req_valid && req_ready;
  assign shift_en  = (state_q == ST_SHIFT) && half_tick && sclk_q && !last_bit;

  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    sdat_d  = sdat_q;
    le_d    = le_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SHIFT;
          sclk_d  = 1'b0;
          sdat_d  = word[0];
        end
      end
      ST_SHIFT: begin
        if (half_tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (last_bit) begin
              state_d = ST_LATCH;
              sdat_d  = 1'b0;
              le_d    = 1'b1;
            end else begin
              sdat_d = next_bit;
            end
          end
        end
      end
      ST_LATCH: begin
        if (le_tick) begin
          le_d    = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        sclk_d  = 1'b0;
        sdat_d  = 1'b0;
        le_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      sdat_q  <= 1'b0;
      le_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      sdat_q  <= sdat_d;
      le_q    <= le_d;
    end
  end

  assign ser_clk  = sclk_q;
  assign ser_data = sdat_q;
  assign ser_le   = le_q;
endmodule

// File: rtl/atten_ser_prog_chk.sv
module atten_ser_prog_chk #(
  parameter int unsigned CLK_NS = 20
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_le
);
  localparam int unsigned MIN_PHASE_NS  = 30;
  localparam int unsigned MIN_PERIOD_NS = 100;
  localparam int unsigned MIN_SETUP_NS  = 10;
  localparam int unsigned MIN_PULSE_NS  = 30;

  logic [15:0] hi_cnt, lo_cnt, le_cnt, rise_gap, hi_prev;
  logic        clk_d;

  function automatic logic [15:0] sat_inc(logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      le_cnt   <= '0;
      rise_gap <= '0;
      hi_prev  <= '0;
      clk_d    <= 1'b0;
    end else begin
      clk_d    <= ser_clk;
      hi_cnt   <= ser_clk ? sat_inc(hi_cnt) : '0;
      lo_cnt   <= ser_clk ? '0 : sat_inc(lo_cnt);
      le_cnt   <= ser_le ? sat_inc(le_cnt) : '0;
      rise_gap <= (ser_clk && !clk_d) ? 16'd1 : sat_inc(rise_gap);
      if (ser_clk) hi_prev <= sat_inc(hi_cnt);
    end
  end

  // R2: data moves only while the shift clock is low
  p_data_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> !ser_clk);

  // R4: strobe never overlaps a high shift clock
  p_le_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);

  // R6: strobe high implies block busy
  p_le_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !req_ready);

  // R6: acceptance drops ready in the next cycle
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: idle wires are low while ready
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ser_clk && !ser_le));

  // R9: high phase width
  p_clk_high_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (32'(hi_cnt) * CLK_NS >= MIN_PHASE_NS));

  // R9: low phase width
  p_clk_low_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> (32'(lo_cnt) * CLK_NS >= MIN_PHASE_NS));

  // R9: shift clock period
  p_clk_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_clk) && hi_prev != 16'd0) |->
      ((32'(lo_cnt) + 32'(hi_prev)) * CLK_NS >= MIN_PERIOD_NS));

  // R9: strobe setup after the last rising edge
  p_le_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le) |-> (32'(rise_gap) * CLK_NS >= MIN_SETUP_NS));

  // R9: strobe pulse width
  p_le_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_le) |-> (32'(le_cnt) * CLK_NS >= MIN_PULSE_NS));
endmodule

bind atten_ser_prog atten_ser_prog_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ser_clk   (ser_clk),
  .ser_data  (ser_data),
  .ser_le    (ser_le)
);

// File: tb/atten_ser_prog_tb.sv
module atten_ser_prog_tb;
  localparam int H   = 3;
  localparam int L   = 2;
  localparam int DBW = 6;
  localparam int SPAN_SHIFT = 16 * H;

  logic clk, rst_n, req_valid;
  logic [DBW-1:0] req_db;
  logic req_ready, ser_clk, ser_data, ser_le;

  atten_ser_prog #(.DB_W(DBW), .HALF_DIV(H), .LE_CYC(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_db(req_db),
    .req_ready(req_ready), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference
  bit       m_busy;
  int       m_k;
  int       m_sync;
  logic [7:0] m_word;
  int       exp_q[$];
  logic [7:0] cap;
  int       ncap;

  function automatic logic [7:0] ref_word(int db);
    int c;
    c = (db > 31) ? 31 : db;
    return 8'(c * 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_sync = 0;
    end else begin
      if (m_sync < 2) m_sync++;
      else if (m_busy) begin
        m_k++;
        if (m_k >= SPAN_SHIFT + L) m_busy = 0;
      end else if (req_valid) begin
        m_busy = 1; m_k = 0; m_word = ref_word(int'(req_db));
      end
    end
  end

  task automatic chk(string tag, string nm, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: got %b expected %b", tag, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!m_busy) begin
        chk("R8", "ser_clk", ser_clk, 1'b0);
        chk("R8", "ser_data", ser_data, 1'b0);
        chk("R8", "ser_le", ser_le, 1'b0);
        chk("R8", "req_ready", req_ready, (rst_n && m_sync >= 2));
      end else if (m_k < SPAN_SHIFT) begin
        chk("R3", "ser_clk", ser_clk, 1'((m_k / H) % 2));
        chk("R2", "ser_data", ser_data, m_word[m_k / (2 * H)]);
        chk("R4", "ser_le", ser_le, 1'b0);
        chk("R6", "req_ready", req_ready, 1'b0);
      end else begin
        chk("R4", "ser_clk", ser_clk, 1'b0);
        chk("R4", "ser_data", ser_data, 1'b0);
        chk("R5", "ser_le", ser_le, 1'b1);
        chk("R6", "req_ready", req_ready, 1'b0);
      end
    end
  end

  // R1 / R7: word reassembled from the wires at each strobe
  always @(posedge ser_clk) begin
    cap = {ser_data, cap[7:1]};
    ncap++;
  end

  always @(posedge ser_le) begin
    n_vec++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R6 unexpected strobe: got word %h expected none", cap);
    end else begin
      int db;
      db = exp_q.pop_front();
      if (cap !== ref_word(db) || ncap != 8) begin
        n_bad++;
        $display("FAIL %s word for %0d dB: got %h (%0d bits) expected %h (8 bits)",
                 (db > 31) ? "R7" : "R1", db, cap, ncap, ref_word(db));
      end
    end
    ncap = 0;
  end

  task automatic send(int db);
    @(negedge clk);
    req_valid = 1'b1;
    req_db    = DBW'(db);
    exp_q.push_back(db);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // R6: offers made while busy must not start a word
  task automatic poke(int db, int n);
    @(negedge clk);
    req_valid = 1'b1;
    req_db    = DBW'(db);
    repeat (n) @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog: got hung run expected completion");
      finish_run();
    end
  end

  initial begin
    ncap = 0; cap = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_db = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(0);
    send(1);
    send(13);
    send(31);
    send(16);
    send(21);
    poke(7, 6);
    send(32);
    send(45);
    send(63);
    poke(2, 4);
    send(10);
    send(5);
    send(26);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule